// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block sits between a host CPU's address bus and a banked program store. It divides the 32 KiB code window at 0x8000–0xFFFF into four 8 KiB slots. Each slot resolves to a physical bank of either ROM or work RAM. A 2-bit mapping mode sets how the four bank registers fill those slots: one 32 KiB region, two 16 KiB regions, a 16 KiB region followed by two 8 KiB regions, or four independent 8 KiB slots. A separate 3-bit bank register places one work-RAM bank in the window at 0x6000–0x7FFF.

Configuration arrives as single-cycle writes, each carrying a 3-bit register select and a data byte. For every CPU address the block returns the following, all combinationally from the current register state:
- which memory to use (ROM or RAM);
- the physical bank, with ROM banks masked to the ROM size and RAM banks folded to the fitted RAM capacity;
- the 13-bit offset within the bank;
- an open-bus flag for RAM banks that do not exist;
- a RAM write enable.

The caller owns both memory arrays. It drives the last bus value back to the CPU whenever the open-bus flag is set.

The register state is the only state in the block. The register file decodes the configuration writes. A slot expander turns the mode and the bank registers into four slot banks. A folding stage turns a 3-bit RAM bank number into a physical bank, in a variant chosen by the RAM-capacity parameter. The mode is held as a named enumeration:
- `MAP_32K` (0)
- `MAP_16K` (1)
- `MAP_16K_8K` (2)
- `MAP_8K` (3)

There are no transitions between modes other than register writes, and a write may move the mode from any value to any other.

Top module: `prgmap_top`

## Requirements
- R1: After reset the mode is `MAP_8K` (3). Bank registers 0, 1 and 2 hold 0x80, bank register 3 holds 0xFF, and the work-RAM bank register holds 0. So with 256 KiB of ROM, slots 0–2 read ROM bank 0 and slot 3 reads ROM bank 31.
- R2: A write with `cfg_we` high uses `cfg_sel` to pick a register:
  - 0 = mode (low 2 bits of the data);
  - 1–4 = bank registers 0–3;
  - 5 = work-RAM bank (low 3 bits of the data);
  - 6 and 7 change nothing.
  A write takes effect on every access from the cycle after its clock edge.
- R3: For a code-window address, the slot is `cpu_addr[14:13]` and `offset` is `cpu_addr[12:0]`.
- R4: Bit 7 of the bank value that a slot uses selects ROM when it is 1 and RAM when it is 0.
- R5: Bit 7 of bank register 3 is forced to 1 on every write, so slot 3 always maps ROM.
- R6: In mode 0, register 3 with bits [1:0] cleared is the base bank, and slot n maps base+n.
- R7: In mode 1, slots 0–1 map register 1 with bit 0 cleared, plus the slot's low bit. Slots 2–3 do the same from register 3.
- R8: In mode 2, slots 0–1 follow the mode 1 rule from register 1, slot 2 maps register 2, and slot 3 maps register 3.
- R9: In mode 3, slot n maps bank register n directly.
- R10: A ROM bank is bits [6:0] of the bank value ANDed with (ROM_KIB/8 − 1).
- R11: A RAM bank uses its low 3 bits, folded by the RAM capacity:
  - 64 KiB: the bank maps directly.
  - 32 KiB: banks 0–3 map as is; 4–7 are unmapped.
  - 16 KiB: the physical bank is bank>>2.
  - 8 KiB: banks 0–3 map to bank 0; 4–7 are unmapped.
  - 0 KiB: every bank is unmapped.
- R12: An access to an unmapped RAM bank raises `open_bus` and never raises `ram_we`.
- R13: A CPU write to a ROM-mapped slot does not raise `ram_we`. A write to a mapped RAM bank does.
- R14: An address in 0x6000–0x7FFF raises `wram_hit` and maps RAM through the work-RAM bank register, using the R11 folding rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for the configuration write |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU access is a write |
| code_hit | output | 1 | Address lies in the code window 0x8000–0xFFFF |
| wram_hit | output | 1 | Address lies in the work-RAM window 0x6000–0x7FFF |
| sel_rom | output | 1 | Access goes to ROM (1) or RAM (0) |
| phys_bank | output | 8 | Physical 8 KiB bank number |
| offset | output | 13 | Byte offset inside the bank |
| open_bus | output | 1 | RAM bank is not fitted; the caller drives the last bus value |
| ram_we | output | 1 | Write enable for the RAM array |

## Verification
A corrupted bank or mode register shows up at the ports at once: every mapping output is combinational from the registers, so the next access to an affected slot returns a wrong `phys_bank` or `sel_rom`. A fault that stays within one mode or one slot stays hidden until that mode is selected or that slot is addressed. This is why the mode tests sweep all four slots. Folding faults show only on RAM accesses, and only for the capacity variant that is built. The `open_bus` and `ram_we` pins expose a wrong mapped/unmapped decision on the first access to the affected bank.

// File: rtl/prgmap_pkg.sv
package prgmap_pkg;

    localparam int SLOTS  = 4;
    localparam int BANK_W = 8;
    localparam int WBNK_W = 3;
    localparam int OFF_W  = 13;

    typedef enum logic [1:0] {
        MAP_32K    = 2'd0,
        MAP_16K    = 2'd1,
        MAP_16K_8K = 2'd2,
        MAP_8K     = 2'd3
    } map_mode_e;

    typedef enum logic [2:0] {
        SEL_MODE  = 3'd0,
        SEL_SLOT0 = 3'd1,
        SEL_SLOT1 = 3'd2,
        SEL_SLOT2 = 3'd3,
        SEL_SLOT3 = 3'd4,
        SEL_WRAM  = 3'd5,
        SEL_RSV6  = 3'd6,
        SEL_RSV7  = 3'd7
    } cfg_sel_e;

    typedef logic [SLOTS-1:0][BANK_W-1:0] bank_regs_t;

    // Bank value seen by one slot for the given mode.
    function automatic logic [BANK_W-1:0] slot_value(map_mode_e mode, bank_regs_t regs, logic [1:0] slot);
        logic [BANK_W-1:0] v;
        unique case (mode)
            MAP_32K:    v = (regs[3] & 8'hFC) | {6'd0, slot};
            MAP_16K:    v = ((slot[1] ? regs[3] : regs[1]) & 8'hFE) | {7'd0, slot[0]};
            MAP_16K_8K: v = slot[1] ? regs[slot] : ((regs[1] & 8'hFE) | {7'd0, slot[0]});
            MAP_8K:     v = regs[slot];
            default:    v = regs[slot];
        endcase
        return v;
    endfunction

endpackage

// File: rtl/prgmap_regs.sv
module prgmap_regs
    import prgmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output map_mode_e         mode_q,
    output bank_regs_t        bank_q,
    output logic [WBNK_W-1:0] wram_q
);

    cfg_sel_e sel_e;
    assign sel_e = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MAP_8K;
            bank_q[0] <= 8'h80;
            bank_q[1] <= 8'h80;
            bank_q[2] <= 8'h80;
            bank_q[3] <= 8'hFF;
            wram_q    <= '0;
        end else if (cfg_we) begin
            unique case (sel_e)
                SEL_MODE:  mode_q    <= map_mode_e'(cfg_wdata[1:0]);
                SEL_SLOT0: bank_q[0] <= cfg_wdata;
                SEL_SLOT1: bank_q[1] <= cfg_wdata;
                SEL_SLOT2: bank_q[2] <= cfg_wdata;
                SEL_SLOT3: bank_q[3] <= cfg_wdata | 8'h80;
                SEL_WRAM:  wram_q    <= cfg_wdata[WBNK_W-1:0];
                SEL_RSV6, SEL_RSV7: ;
                default: ;
            endcase
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == 3'd0) |=> $stable(mode_q)); // R2

    AST_WRAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == 3'd5) |=> $stable(wram_q)); // R14

endmodule

// File: rtl/prgmap_slot_expand.sv
module prgmap_slot_expand
    import prgmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  map_mode_e         mode,
    input  bank_regs_t        regs,
    input  logic [1:0]        slot_idx,
    output logic [BANK_W-1:0] sel_bank
);

    logic [BANK_W-1:0] slot_bank [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_bank[g] = slot_value(mode, regs, 2'(g));
    end

    assign sel_bank = slot_bank[slot_idx];

    AST_MODE0_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MAP_32K) |-> (slot_bank[3] == slot_bank[0] + 8'd3)); // R6

    AST_MODE1_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MAP_16K) |-> (slot_bank[1] == (slot_bank[0] | 8'h01))); // R7

endmodule

// File: rtl/prgmap_ram_fold.sv
module prgmap_ram_fold
    import prgmap_pkg::*;
#(
    parameter int RAM_KIB = 64
) (
    input  logic [WBNK_W-1:0] bank,
    output logic              mapped,
    output logic [WBNK_W-1:0] phys
);

    localparam int RAM_BANKS = RAM_KIB / 8;

    if (RAM_KIB == 64) begin : g_direct
        assign mapped = 1'b1;
        assign phys   = bank;
    end else if (RAM_KIB == 32) begin : g_half
        assign mapped = ~bank[2];
        assign phys   = bank & 3'b011;
    end else if (RAM_KIB == 16) begin : g_quarter
        assign mapped = 1'b1;
        assign phys   = bank >> 2;
    end else if (RAM_KIB == 8) begin : g_single
        assign mapped = ~bank[2];
        assign phys   = bank & 3'b000;
    end else begin : g_none
        assign mapped = 1'b0;
        assign phys   = bank & 3'b000;
    end

    always_comb begin
        if (mapped) begin
            AST_FOLD_IN_RANGE: assert (int'(phys) < RAM_BANKS); // R11
        end
    end

endmodule

// File: rtl/prgmap_top.sv
module prgmap_top
    import prgmap_pkg::*;
#(
    parameter int ROM_KIB = 256,
    parameter int RAM_KIB = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    output logic        code_hit,
    output logic        wram_hit,
    output logic        sel_rom,
    output logic [7:0]  phys_bank,
    output logic [12:0] offset,
    output logic        open_bus,
    output logic        ram_we
);

    localparam int         ROM_BANKS = ROM_KIB / 8;
    localparam logic [6:0] ROM_MASK  = 7'(ROM_BANKS - 1);

    map_mode_e         mode_q;
    bank_regs_t        bank_q;
    logic [WBNK_W-1:0] wram_q;
    logic [BANK_W-1:0] sel_bank;
    logic [WBNK_W-1:0] ram_bank;
    logic [WBNK_W-1:0] ram_phys;
    logic              ram_mapped;
    logic              any_hit;

    prgmap_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .mode_q    (mode_q),
        .bank_q    (bank_q),
        .wram_q    (wram_q)
    );

    prgmap_slot_expand u_expand (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .regs     (bank_q),
        .slot_idx (cpu_addr[14:13]),
        .sel_bank (sel_bank)
    );

    assign code_hit = cpu_addr[15];
    assign wram_hit = (cpu_addr[15:13] == 3'b011);
    assign any_hit  = code_hit | wram_hit;
    assign ram_bank = code_hit ? sel_bank[WBNK_W-1:0] : wram_q;

    prgmap_ram_fold #(.RAM_KIB(RAM_KIB)) u_fold (
        .bank   (ram_bank),
        .mapped (ram_mapped),
        .phys   (ram_phys)
    );

    always_comb begin
        sel_rom   = code_hit & sel_bank[7];
        offset    = cpu_addr[OFF_W-1:0];
        phys_bank = '0;
        open_bus  = 1'b0;
        ram_we    = 1'b0;
        if (sel_rom) begin
            phys_bank = {1'b0, sel_bank[6:0] & ROM_MASK};
        end else if (any_hit) begin
            phys_bank = {5'd0, ram_phys};
            open_bus  = ~ram_mapped;
            ram_we    = cpu_wr & ram_mapped;
        end
    end

    AST_LAST_SLOT_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (code_hit && cpu_addr[14:13] == 2'd3) |-> sel_rom); // R5

    AST_ROM_BANK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rom |-> (int'(phys_bank) < ROM_BANKS)); // R10

    AST_NO_ROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rom |-> !ram_we); // R13

    AST_OPEN_BUS_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> !ram_we); // R12

    AST_WRAM_IS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        wram_hit |-> !sel_rom); // R14

endmodule

// File: tb/prgmap_top_tb.sv
module prgmap_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;

    logic        code_hit, wram_hit, sel_rom, open_bus, ram_we;
    logic [7:0]  phys_bank;
    logic [12:0] offset;

    logic        v_code [4], v_wram [4], v_rom [4], v_ob [4], v_we [4];
    logic [7:0]  v_pb [4];
    logic [12:0] v_off [4];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10ns clk = ~clk;

    prgmap_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .code_hit(code_hit), .wram_hit(wram_hit),
        .sel_rom(sel_rom), .phys_bank(phys_bank), .offset(offset), .open_bus(open_bus), .ram_we(ram_we)
    );

    // Variants: index 0 = 32 KiB, 1 = 16 KiB, 2 = 8 KiB, 3 = no RAM
    for (genvar k = 0; k < 4; k++) begin : g_var
        localparam int KIB = (k == 0) ? 32 : (k == 1) ? 16 : (k == 2) ? 8 : 0;
        prgmap_top #(.ROM_KIB(256), .RAM_KIB(KIB)) dut_v (
            .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
            .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .code_hit(v_code[k]), .wram_hit(v_wram[k]),
            .sel_rom(v_rom[k]), .phys_bank(v_pb[k]), .offset(v_off[k]), .open_bus(v_ob[k]), .ram_we(v_we[k])
        );
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic wr);
        cpu_addr = a; cpu_wr = wr;
        #1;
    endtask

    task automatic expect_map(input string req, input logic [15:0] a, input int rom, input int bank);
        probe(a, 1'b0);
        check(req, $sformatf("sel_rom @%h", a), int'(sel_rom), rom);
        check(req, $sformatf("phys_bank @%h", a), int'(phys_bank), bank);
    endtask

    task automatic t_reset();
        expect_map("R1", 16'h8000, 1, 0);
        expect_map("R1", 16'hA000, 1, 0);
        expect_map("R1", 16'hE000, 1, 31);
        probe(16'h6000, 1'b0);
        check("R1", "wram bank", int'(phys_bank), 0);
        check("R1", "wram open_bus", int'(open_bus), 0);
    endtask

    task automatic t_mode3();
        cfg_write(3'd1, 8'h05);
        cfg_write(3'd2, 8'h83);
        cfg_write(3'd3, 8'hE5);
        expect_map("R4", 16'h8123, 0, 5);
        check("R3", "offset", int'(offset), 'h123);
        check("R3", "code_hit", int'(code_hit), 1);
        expect_map("R9", 16'hA000, 1, 3);
        expect_map("R10", 16'hDFFF, 1, 5);
        check("R3", "offset top", int'(offset), 'h1FFF);
    endtask

    task automatic t_force();
        cfg_write(3'd4, 8'h04);
        expect_map("R5", 16'hE000, 1, 4);
    endtask

    task automatic t_mode0();
        cfg_write(3'd0, 8'h00);
        expect_map("R2", 16'h8000, 1, 4);
        cfg_write(3'd4, 8'h07);
        expect_map("R6", 16'h8000, 1, 4);
        expect_map("R6", 16'hA000, 1, 5);
        expect_map("R6", 16'hC000, 1, 6);
        expect_map("R6", 16'hE000, 1, 7);
    endtask

    task automatic t_mode1();
        cfg_write(3'd0, 8'h01);
        cfg_write(3'd2, 8'h03);
        cfg_write(3'd4, 8'h8B);
        expect_map("R7", 16'h8000, 0, 2);
        expect_map("R7", 16'hA000, 0, 3);
        expect_map("R7", 16'hC000, 1, 10);
        expect_map("R7", 16'hE000, 1, 11);
    endtask

    task automatic t_mode2();
        cfg_write(3'd0, 8'h02);
        cfg_write(3'd2, 8'h85);
        cfg_write(3'd3, 8'h02);
        expect_map("R8", 16'h8000, 1, 4);
        expect_map("R8", 16'hA000, 1, 5);
        expect_map("R8", 16'hC000, 0, 2);
        expect_map("R8", 16'hE000, 1, 11);
    endtask

    task automatic t_decode();
        cfg_write(3'd6, 8'h00);
        cfg_write(3'd7, 8'h00);
        expect_map("R2", 16'hC000, 0, 2);
        expect_map("R2", 16'h8000, 1, 4);
        cfg_write(3'd0, 8'hFF);
        expect_map("R2", 16'h8000, 0, 5);
    endtask

    task automatic t_fold();
        cfg_write(3'd5, 8'hFD);
        probe(16'h6010, 1'b1);
        check("R14", "wram_hit", int'(wram_hit), 1);
        check("R14", "wram sel_rom", int'(sel_rom), 0);
        check("R14", "64K bank", int'(phys_bank), 5);
        check("R14", "wram offset", int'(offset), 'h10);
        check("R11", "64K we", int'(ram_we), 1);
        check("R12", "32K open_bus b5", int'(v_ob[0]), 1);
        check("R12", "32K we b5", int'(v_we[0]), 0);
        check("R11", "16K bank b5", int'(v_pb[1]), 1);
        check("R11", "16K we b5", int'(v_we[1]), 1);
        check("R12", "8K open_bus b5", int'(v_ob[2]), 1);
        check("R12", "0K open_bus b5", int'(v_ob[3]), 1);
        cfg_write(3'd5, 8'h03);
        probe(16'h7FFF, 1'b1);
        check("R11", "32K bank b3", int'(v_pb[0]), 3);
        check("R11", "32K ob b3", int'(v_ob[0]), 0);
        check("R11", "16K bank b3", int'(v_pb[1]), 0);
        check("R11", "8K bank b3", int'(v_pb[2]), 0);
        check("R11", "8K ob b3", int'(v_ob[2]), 0);
        check("R12", "0K ob b3", int'(v_ob[3]), 1);
        check("R12", "0K we b3", int'(v_we[3]), 0);
    endtask

    task automatic t_rom_write();
        probe(16'hE000, 1'b1);
        check("R13", "rom slot we", int'(ram_we), 0);
        check("R13", "rom slot sel", int'(sel_rom), 1);
        probe(16'h8000, 1'b1);
        check("R13", "ram slot we", int'(ram_we), 1);
        check("R11", "32K code b5 open_bus", int'(v_ob[0]), 1);
        probe(16'h5000, 1'b1);
        check("R14", "outside hit", int'(code_hit | wram_hit), 0);
        check("R13", "outside we", int'(ram_we), 0);
        cpu_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode3();
        t_force();
        t_mode0();
        t_mode1();
        t_mode2();
        t_decode();
        t_fold();
        t_rom_write();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule